// File: doc/BRIEF.md
# Masked Vectored Interrupt Controller

This block watches a bank of condition indicators and decides when the instruction sequencer should be interrupted. Each indicator is a sticky bit: a one-cycle set pulse latches it, and it stays on until software clears it or the controller takes an interrupt for it. Indicators that concern only the running program are gated by mask bits that software can write. Indicators for system-wide conditions have masks held permanently on, so those events are never suppressed and never lost.

An interrupt is taken only when the controller is enabled, the sequencer reports that the current instruction has nothing left to do, and at least one indicator is both on and unmasked. The lowest-numbered such indicator wins. The controller then issues a one-cycle take strobe, together with a fetch address equal to a relocatable table base plus the winning index. The sequencer fetches one interjected instruction from that address and leaves its own instruction counter unchanged. Taking the interrupt acknowledges the winning indicator and clears the enable, so that interrupts do not nest until software turns the enable back on. Software reloads the table base when it switches programs, which allows each program to keep its own table in memory.

Top module: `vec_intr_ctrl`

## Requirements
- R1: `take_o` rises only if, in the cycle before it, the enable was on, `quiet_i` was high, and some indicator was both on and unmasked.
- R2: A write with `wr_sel`=0 loads the private mask bits from `wr_data`. An indicator whose private mask bit is 0 is held pending but does not cause a take.
- R3: Indicators whose bit is set in `FIXED_MASK` (default bits 27 to 31) cause a take whatever `wr_sel`=0 writes.
- R4: Indicators are sticky. A `set_i` pulse latches the bit. A write with `wr_sel`=1 clears the bits where `wr_data` is 1. When a set pulse and a clear arrive in the same cycle, the set wins.
- R5: `take_o` is a one-cycle strobe, registered one clock after the decision. In the same cycle `idx_o` holds the winning index and `vec_o` holds the table base plus that index, modulo 2^ADDR_W.
- R6: When several unmasked indicators are on, the lowest index wins.
- R7: A take clears the winning indicator and clears the enable. Further pending indicators wait until the enable is written back to 1.
- R8: A write with `wr_sel`=2 loads the table base from the low ADDR_W bits of `wr_data`. Vectors issued afterwards use the new base.
- R9: A write with `wr_sel`=3 sets the enable to `wr_data[0]`. After reset the enable, the indicators, the private masks, the base and all outputs are 0.
- R10: While `quiet_i` is low no take occurs. Pending indicators are kept, and they are served once `quiet_i` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_i | input | N_IND | Per-indicator set pulses |
| quiet_i | input | 1 | Current instruction has no further activity |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 mask, 1 clear, 2 base, 3 enable |
| wr_data | input | N_IND | Write data |
| take_o | output | 1 | Interrupt-take strobe |
| vec_o | output | ADDR_W | Fetch address of the interjected instruction |
| idx_o | output | IDX_W | Index of the winning indicator |

## Verification
The bench walks every one of the 32 indicators with a different table base for each. This catches a vector built from the wrong base or index, or an off-by-one in the sum. For every index it also fires the same indicator again while the enable is off. A design that failed to drop its enable on a take would nest, and one that failed to acknowledge the indicator would fire a second time after re-enable. Dedicated cases cover the following:
- a private mask of zero alongside a fixed-mask bit, where a design that lets a mask write reach a system-wide bit would lose the event;
- a set pulse and a clear in the same cycle, where clear-wins logic would drop the event;
- three simultaneous indicators, where a priority encoder with the wrong direction picks the highest;
- `quiet_i` held low, where ignoring it would interrupt mid-instruction.

// File: rtl/vec_intr_pkg.sv
package vec_intr_pkg;

    typedef enum logic [1:0] {
        SEL_MASK = 2'd0,
        SEL_CLR  = 2'd1,
        SEL_BASE = 2'd2,
        SEL_EN   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     we;
        reg_sel_e sel;
    } wr_cmd_t;

    function automatic logic hits(input wr_cmd_t c, input reg_sel_e s);
        return c.we && (c.sel == s);
    endfunction

endpackage

// File: rtl/vec_intr_bank.sv
module vec_intr_bank #(
    parameter int          N_IND      = 32,
    parameter logic [N_IND-1:0] FIXED_MASK = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_IND-1:0] set_i,
    input  logic [N_IND-1:0] clr_i,
    input  logic [N_IND-1:0] ack_i,
    input  logic             mask_we,
    input  logic [N_IND-1:0] mask_d,
    output logic [N_IND-1:0] ind_q,
    output logic [N_IND-1:0] pend_o
);
    logic [N_IND-1:0] mask_q;
    logic [N_IND-1:0] eff_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            ind_q  <= '0;
            mask_q <= '0;
        end else begin
            ind_q <= (ind_q & ~clr_i & ~ack_i) | set_i;
            if (mask_we)
                mask_q <= mask_d;
        end
    end

    // per bit: fixed positions bypass the writable mask entirely
    for (genvar g = 0; g < N_IND; g++) begin : g_mask
        if (FIXED_MASK[g]) begin : g_fixed
            assign eff_mask[g] = 1'b1;
        end else begin : g_priv
            assign eff_mask[g] = mask_q[g];
        end
    end

    assign pend_o = ind_q & eff_mask;

endmodule

// File: rtl/vec_intr_pick.sv
module vec_intr_pick #(
    parameter int N_IND = 32,
    localparam int IDX_W = $clog2(N_IND)
) (
    input  logic [N_IND-1:0] req_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int k = N_IND - 1; k >= 0; k--) begin
            if (req_i[k])
                idx_o = IDX_W'(k);
        end
    end

    assign hit_o = |req_i;

endmodule

// File: rtl/vec_intr_ctrl.sv
module vec_intr_ctrl
    import vec_intr_pkg::*;
#(
    parameter int               N_IND      = 32,
    parameter int               ADDR_W     = 18,
    parameter logic [N_IND-1:0] FIXED_MASK = 32'hF800_0000,
    localparam int              IDX_W      = $clog2(N_IND)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_IND-1:0]  set_i,
    input  logic              quiet_i,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [N_IND-1:0]  wr_data,
    output logic              take_o,
    output logic [ADDR_W-1:0] vec_o,
    output logic [IDX_W-1:0]  idx_o
);
    wr_cmd_t           cmd;
    logic              en_q;
    logic [ADDR_W-1:0] base_q;
    logic [N_IND-1:0]  ind_q;
    logic [N_IND-1:0]  pend;
    logic [N_IND-1:0]  ack;
    logic [N_IND-1:0]  clr;
    logic              hit;
    logic [IDX_W-1:0]  win;
    logic              take_now;

    assign cmd.we  = wr_en;
    assign cmd.sel = reg_sel_e'(wr_sel);

    assign clr      = hits(cmd, SEL_CLR) ? wr_data : '0;
    assign take_now = en_q && quiet_i && hit;
    assign ack      = take_now ? (N_IND'(1) << win) : '0;

    vec_intr_bank #(
        .N_IND      (N_IND),
        .FIXED_MASK (FIXED_MASK)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .set_i   (set_i),
        .clr_i   (clr),
        .ack_i   (ack),
        .mask_we (hits(cmd, SEL_MASK)),
        .mask_d  (wr_data),
        .ind_q   (ind_q),
        .pend_o  (pend)
    );

    vec_intr_pick #(
        .N_IND (N_IND)
    ) u_pick (
        .req_i (pend),
        .hit_o (hit),
        .idx_o (win)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            base_q <= '0;
            take_o <= 1'b0;
            vec_o  <= '0;
            idx_o  <= '0;
        end else begin
            if (take_now)
                en_q <= 1'b0;
            else if (hits(cmd, SEL_EN))
                en_q <= wr_data[0];
            if (hits(cmd, SEL_BASE))
                base_q <= wr_data[ADDR_W-1:0];
            take_o <= take_now;
            if (take_now) begin
                idx_o <= win;
                vec_o <= base_q + ADDR_W'(win);
            end
        end
    end

endmodule

// File: rtl/vec_intr_ctrl_chk.sv
module vec_intr_ctrl_chk #(
    parameter int               N_IND      = 32,
    parameter int               ADDR_W     = 18,
    parameter logic [N_IND-1:0] FIXED_MASK = '0,
    localparam int              IDX_W      = $clog2(N_IND)
) (
    input logic              clk,
    input logic              rst,
    input logic              quiet_i,
    input logic              take_o,
    input logic [ADDR_W-1:0] vec_o,
    input logic [IDX_W-1:0]  idx_o,
    input logic              en_q,
    input logic [ADDR_W-1:0] base_q,
    input logic [N_IND-1:0]  ind_q,
    input logic [N_IND-1:0]  pend,
    input logic [N_IND-1:0]  set_i
);
    assert_take_cond_R1: assert property (@(posedge clk) disable iff (rst)
        take_o |-> ($past(en_q) && $past(quiet_i) && ($past(pend) != '0)));

    assert_quiet_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !quiet_i |=> !take_o);

    assert_fixed_unmasked_R3: assert property (@(posedge clk) disable iff (rst)
        ((ind_q & FIXED_MASK & ~pend) == '0));

    assert_vector_R5: assert property (@(posedge clk) disable iff (rst)
        take_o |-> (vec_o == $past(base_q) + ADDR_W'(idx_o)));

    assert_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        take_o |=> !take_o);

    assert_lowest_wins_R6: assert property (@(posedge clk) disable iff (rst)
        take_o |-> (($past(pend) & ((N_IND'(1) << idx_o) - N_IND'(1))) == '0));

    assert_auto_disable_R7: assert property (@(posedge clk) disable iff (rst)
        take_o |-> !en_q);

    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (rst)
        take_o && !$past(set_i[idx_o]) |-> !ind_q[idx_o]);

endmodule

bind vec_intr_ctrl vec_intr_ctrl_chk #(
    .N_IND      (N_IND),
    .ADDR_W     (ADDR_W),
    .FIXED_MASK (FIXED_MASK)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .quiet_i (quiet_i),
    .take_o  (take_o),
    .vec_o   (vec_o),
    .idx_o   (idx_o),
    .en_q    (en_q),
    .base_q  (base_q),
    .ind_q   (ind_q),
    .pend    (pend),
    .set_i   (set_i)
);

// File: tb/test_vec_intr_ctrl.sv
module test_vec_intr_ctrl;
    localparam int N  = 32;
    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  set_i = '0;
    logic          quiet_i = 1'b1;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = '0;
    logic [N-1:0]  wr_data = '0;
    logic          take_o;
    logic [AW-1:0] vec_o;
    logic [4:0]    idx_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    vec_intr_ctrl i_vec_intr_ctrl (
        .clk     (clk),
        .rst     (rst),
        .set_i   (set_i),
        .quiet_i (quiet_i),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .take_o  (take_o),
        .vec_o   (vec_o),
        .idx_o   (idx_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [N-1:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulse(input logic [N-1:0] v);
        set_i = v;
        @(negedge clk);
        set_i = '0;
    endtask

    // sample the cycle after a decision and check a take with given index/vector
    task automatic expect_take(input string req, input int idx, input logic [AW-1:0] base);
        logic [AW-1:0] ev;
        @(negedge clk);
        ev = base + AW'(idx);
        chk(take_o == 1'b1, req, 32'(take_o), 32'd1);
        chk(idx_o == 5'(idx), req, 32'(idx_o), 32'(idx));
        chk(vec_o == ev, req, 32'(vec_o), 32'(ev));
    endtask

    task automatic expect_none(input string req, input int cycles);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            chk(take_o == 1'b0, req, 32'(take_o), 32'd0);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] base;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9: reset state
        chk(take_o == 0, "R9 reset take", 32'(take_o), 0);
        chk(vec_o == 0,  "R9 reset vec",  32'(vec_o), 0);
        chk(idx_o == 0,  "R9 reset idx",  32'(idx_o), 0);
        // R9: enable off after reset, indicator pending not taken
        pulse(32'h0000_0001 << 28);
        expect_none("R9 enable off after reset", 2);
        wr(2'd1, 32'hFFFF_FFFF);

        // R2 open all private masks, then sweep every indicator (R5 R8 R7 R4)
        wr(2'd0, 32'hFFFF_FFFF);
        for (int i = 0; i < N; i++) begin
            base = AW'(i * 4099 + 17);
            wr(2'd2, N'(base));                 // R8
            wr(2'd3, 32'd1);
            pulse(N'(1) << i);
            expect_take("R5 R8 sweep", i, base);
            expect_none("R5 strobe one cycle", 1);
            pulse(N'(1) << i);                  // R7 enable cleared: no nesting
            expect_none("R7 auto disable", 2);
            wr(2'd3, 32'd1);                    // R4 sticky pending served
            expect_take("R4 sticky after re-enable", i, base);
            wr(2'd3, 32'd1);                    // R7 indicator acknowledged
            expect_none("R7 ack clears indicator", 2);
        end
        base = AW'(31 * 4099 + 17);

        // R2 / R3: private masks closed, fixed bit still taken
        wr(2'd0, 32'h0);
        wr(2'd3, 32'd1);
        pulse(32'h0000_0004);
        expect_none("R2 masked private", 2);
        pulse(32'h0800_0000);
        expect_take("R3 fixed mask bit 27", 27, base);
        wr(2'd3, 32'd1);
        expect_none("R2 private still masked", 2);
        wr(2'd0, 32'h0000_0004);
        expect_take("R2 mask opened", 2, base);

        // R4: clear write removes pending; set wins over clear same cycle
        pulse(32'h0000_0020);
        wr(2'd1, 32'h0000_0020);
        wr(2'd0, 32'hFFFF_FFFF);
        wr(2'd3, 32'd1);
        expect_none("R4 clear write", 2);
        wr(2'd3, 32'd0);
        set_i = 32'h0000_0040;
        wr(2'd1, 32'h0000_0040);
        set_i = '0;
        wr(2'd3, 32'd1);
        expect_take("R4 set wins over clear", 6, base);

        // R6: lowest index wins among several
        pulse(32'h4000_0210);
        wr(2'd3, 32'd1);
        expect_take("R6 lowest first", 4, base);
        wr(2'd3, 32'd1);
        expect_take("R6 second", 9, base);
        wr(2'd3, 32'd1);
        expect_take("R6 third", 30, base);
        // R6 with lowest masked out
        wr(2'd0, 32'hFFFF_FFF7);
        pulse(32'h0000_0108);
        wr(2'd3, 32'd1);
        expect_take("R6 lowest unmasked", 8, base);
        wr(2'd1, 32'hFFFF_FFFF);

        // R10 / R1: quiet low holds off
        quiet_i = 1'b0;
        wr(2'd3, 32'd1);
        pulse(32'h0000_0002);
        expect_none("R10 quiet low", 3);
        quiet_i = 1'b1;
        expect_take("R1 R10 served when quiet", 1, base);

        expect_none("R1 idle", 2);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule